// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and calendar date as a chain of packed BCD counters: hundredths of a second, seconds, minutes, hours, day of week, date, month and two-digit year. A fractional prescaler turns the 32.768 kHz clock into a hundredth-second enable. Each enable steps the chain, and every carry ripples upward through the calendar in the same cycle. Hours run in either 24-hour or 12-hour form with an AM/PM flag. February gets its 29th day whenever the year value is a multiple of four, which is correct for years up to 2100.

The host sets any field through a single-cycle write port. The same write restarts the sub-second prescaler, so a freshly written value lasts a full hundredth before it first steps. Any field can be read back through a registered read port. An enable input starts and stops the timebase. While it is low, the prescaler and all counters hold their values.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the fields read hundredths 0x00, seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode), day 0x01, date 0x01, month 0x01, year 0x00.
- R2: Field select codes are 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. A write stores the data masked as follows: hundredths and year keep all 8 bits, seconds, minutes and hours keep bits 6:0, day keeps bits 2:0, date keeps bits 5:0 and month keeps bits 4:0. The read port returns the selected field one clock after rd_sel is applied.
- R3: With run_en high, the prescaler produces exactly 100 hundredth-second steps in every 32768 clocks, using periods of 327 and 328 clocks. After a write, the first step lands on the 328th enabled clock.
- R4: While run_en is low, no field changes unless it is written.
- R5: Hundredths count 00–99, and seconds and minutes count 00–59, all in BCD. Each wraps to 00 and carries into the next field.
- R6: When hours bit 6 is 0 (24-hour mode), hours bits 5:0 count BCD 00–23, and 23 wraps to 00 with a carry into the date.
- R7: When hours bit 6 is 1 (12-hour mode), bit 5 is PM and bits 4:0 count BCD 01–12. The step 11→12 toggles PM, and 12→01 leaves PM unchanged. The date advances on the 11 PM → 12 AM step.
- R8: Day of week counts 01–07 and advances exactly when the date advances, with 07 wrapping to 01.
- R9: Months 01, 03, 05, 07, 08, 10 and 12 end after day 31. Months 04, 06, 09 and 11 end after day 30. February ends after 28 days in a non-leap year. The date then returns to 01 and the month advances.
- R10: A year whose BCD value is divisible by four, including 00, is a leap year, and February then ends after day 29.
- R11: Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R12: A write to any field restarts the prescaler, so the next step comes a full 328 enabled clocks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz time-base clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Oscillator enable; low freezes prescaler and counters |
| wr_en | input | 1 | Host field write strobe |
| wr_sel | input | 3 | Field select for writes |
| wr_data | input | 8 | Packed BCD write data |
| rd_sel | input | 3 | Field select for reads |
| rd_data | output | 8 | Registered read data for the selected field |

## Verification
The assertions check, on every cycle, that:
- hundredths step by one BCD count or hold;
- seconds move only on a hundredths wrap;
- nothing moves while the enable is low;
- the day of week and the date change together;
- the PM flag changes only on the 11→12 step;
- a valid 24-hour hour stays in range.

Some behaviours only the directed scenarios can show. These are the exact 327/328 tick spacing and the prescaler restart on a write. They also include the month-length and leap-year decisions for particular dates and the full year-end rollover.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 8;

  typedef enum logic [2:0] {
    F_HUND  = 3'd0,
    F_SEC   = 3'd1,
    F_MIN   = 3'd2,
    F_HOUR  = 3'd3,
    F_DAY   = 3'd4,
    F_DATE  = 3'd5,
    F_MONTH = 3'd6,
    F_YEAR  = 3'd7
  } field_e;

  // Step a packed two-digit BCD value by one (no wrap handling).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // BCD year divisible by four: even tens with units 0/4/8, odd tens with units 2/6.
  function automatic logic is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mo, input logic [7:0] yr);
    case (mo)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int BASE_HZ = 32768,
  parameter int TICK_HZ = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  input  logic clr,
  output logic tick
);
  localparam int ACC_W = $clog2(BASE_HZ + TICK_HZ);
  localparam logic [ACC_W-1:0] STEP  = ACC_W'(TICK_HZ);
  localparam logic [ACC_W-1:0] LIMIT = ACC_W'(BASE_HZ);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;

  always_comb begin
    acc_sum = acc_q + STEP;
    tick    = run_en && !clr && (acc_sum >= LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  acc_q <= '0;
    else if (run_en) acc_q <= tick ? (acc_sum - LIMIT) : acc_sum;
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [2:0]   wr_sel,
  input  logic [7:0]   wr_data,
  output logic [7:0]   hund_o,
  output logic [7:0]   sec_o,
  output logic [7:0]   min_o,
  output logic [7:0]   hour_o,
  output logic         day_carry
);
  logic c_sec, c_min, c_hr;
  logic [7:0] hour_nx;

  function automatic logic [7:0] next_hour(input logic [7:0] h);
    logic [7:0] s;
    if (h[6]) begin
      s = bcd_inc({3'b000, h[4:0]});
      if (h[4:0] == 5'h12)      return {2'b01, h[5], 5'h01};
      else if (h[4:0] == 5'h11) return {2'b01, ~h[5], 5'h12};
      else                      return {2'b01, h[5], s[4:0]};
    end else begin
      s = bcd_inc({2'b00, h[5:0]});
      if (h[5:0] == 6'h23) return 8'h00;
      else                 return {2'b00, s[5:0]};
    end
  endfunction

  always_comb begin
    c_sec     = tick  && (hund_o == 8'h99);
    c_min     = c_sec && (sec_o  == 8'h59);
    c_hr      = c_min && (min_o  == 8'h59);
    day_carry = c_hr && (hour_o[6] ? (hour_o[5] && hour_o[4:0] == 5'h11)
                                   : (hour_o[5:0] == 6'h23));
    hour_nx   = next_hour(hour_o);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hund_o <= 8'h00;
      sec_o  <= 8'h00;
      min_o  <= 8'h00;
      hour_o <= 8'h00;
    end else begin
      if (wr_en && wr_sel == F_HUND) hund_o <= wr_data;
      else if (tick)                 hund_o <= (hund_o == 8'h99) ? 8'h00 : bcd_inc(hund_o);

      if (wr_en && wr_sel == F_SEC)  sec_o <= {1'b0, wr_data[6:0]};
      else if (c_sec)                sec_o <= (sec_o == 8'h59) ? 8'h00 : bcd_inc(sec_o);

      if (wr_en && wr_sel == F_MIN)  min_o <= {1'b0, wr_data[6:0]};
      else if (c_min)                min_o <= (min_o == 8'h59) ? 8'h00 : bcd_inc(min_o);

      if (wr_en && wr_sel == F_HOUR) hour_o <= {1'b0, wr_data[6:0]};
      else if (c_hr)                 hour_o <= hour_nx;
    end
  end
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         day_carry,
  input  logic         wr_en,
  input  logic [2:0]   wr_sel,
  input  logic [7:0]   wr_data,
  output logic [7:0]   day_o,
  output logic [7:0]   date_o,
  output logic [7:0]   month_o,
  output logic [7:0]   year_o
);
  logic c_mon, c_yr;

  always_comb begin
    c_mon = day_carry && (date_o == month_len(month_o, year_o));
    c_yr  = c_mon && (month_o == 8'h12);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      day_o   <= 8'h01;
      date_o  <= 8'h01;
      month_o <= 8'h01;
      year_o  <= 8'h00;
    end else begin
      if (wr_en && wr_sel == F_DAY)   day_o <= {5'b0, wr_data[2:0]};
      else if (day_carry)             day_o <= (day_o == 8'h07) ? 8'h01 : bcd_inc(day_o);

      if (wr_en && wr_sel == F_DATE)  date_o <= {2'b0, wr_data[5:0]};
      else if (day_carry)             date_o <= c_mon ? 8'h01 : bcd_inc(date_o);

      if (wr_en && wr_sel == F_MONTH) month_o <= {3'b0, wr_data[4:0]};
      else if (c_mon)                 month_o <= c_yr ? 8'h01 : bcd_inc(month_o);

      if (wr_en && wr_sel == F_YEAR)  year_o <= wr_data;
      else if (c_yr)                  year_o <= (year_o == 8'h99) ? 8'h00 : bcd_inc(year_o);
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int BASE_HZ = 32768,
  parameter int TICK_HZ = 100
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_en,
  input  logic         wr_en,
  input  logic [2:0]   wr_sel,
  input  logic [7:0]   wr_data,
  input  logic [2:0]   rd_sel,
  output logic [7:0]   rd_data
);
  logic tick, day_carry;
  logic [7:0] hund_q, sec_q, min_q, hour_q, day_q, date_q, month_q, year_q;
  logic [FIELD_W-1:0] fld [NUM_FIELDS];

  rtc_prescaler #(.BASE_HZ(BASE_HZ), .TICK_HZ(TICK_HZ)) u_pre (
    .clk(clk), .rst(rst), .run_en(run_en), .clr(wr_en), .tick(tick)
  );

  rtc_time_chain u_time (
    .clk(clk), .rst(rst), .tick(tick),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hund_o(hund_q), .sec_o(sec_q), .min_o(min_q), .hour_o(hour_q),
    .day_carry(day_carry)
  );

  rtc_date_chain u_date (
    .clk(clk), .rst(rst), .day_carry(day_carry),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .day_o(day_q), .date_o(date_q), .month_o(month_q), .year_o(year_q)
  );

  always_comb begin
    fld[F_HUND]  = hund_q;
    fld[F_SEC]   = sec_q;
    fld[F_MIN]   = min_q;
    fld[F_HOUR]  = hour_q;
    fld[F_DAY]   = day_q;
    fld[F_DATE]  = date_q;
    fld[F_MONTH] = month_q;
    fld[F_YEAR]  = year_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= fld[rd_sel];
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       run_en,
  input logic       wr_en,
  input logic [7:0] hund,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hour,
  input logic [7:0] day,
  input logic [7:0] date,
  input logic [7:0] month,
  input logic [7:0] year
);
  AST_HUND_STEP: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (hund == $past(hund)) || (hund == bcd_inc($past(hund))) ||
               ($past(hund) == 8'h99 && hund == 8'h00)); // R5

  AST_SEC_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && hund != 8'h99) |=> $stable(sec)); // R5

  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !wr_en) |=> $stable(hund) && $stable(sec) && $stable(min) &&
      $stable(hour) && $stable(day) && $stable(date) && $stable(month) && $stable(year)); // R4

  AST_DAY_WITH_DATE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(day) == $stable(date))); // R8

  AST_PM_ON_ELEVEN: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && hour[6] && hour[4:0] != 5'h11) |=> $stable(hour[5])); // R7

  AST_HOUR24_RANGE: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !hour[6] && hour[5:0] <= 6'h23) |=> (hour[6] || hour[5:0] <= 6'h23)); // R6
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .wr_en(wr_en),
  .hund(hund_q), .sec(sec_q), .min(min_q), .hour(hour_q),
  .day(day_q), .date(date_q), .month(month_q), .year(year_q)
);

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_sel = '0;
  logic [7:0] rd_data;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_calendar u_dut (
    .clk(clk), .rst(rst), .run_en(run_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge.
  task automatic wr(input logic [2:0] sel, input logic [7:0] val);
    wr_sel = sel; wr_data = val; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [7:0] val);
    rd_sel = sel;
    @(negedge clk);
    val = rd_data;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] sel, input logic [7:0] exp);
    logic [7:0] v;
    rd(sel, v);
    chk(tag, v, exp);
  endtask

  task automatic set_all(input logic [7:0] hu, se, mi, hr, dy, dt, mo, yr);
    wr(3'd7, yr); wr(3'd6, mo); wr(3'd5, dt); wr(3'd4, dy);
    wr(3'd3, hr); wr(3'd2, mi); wr(3'd1, se); wr(3'd0, hu);
  endtask

  // One hundredth step after the last write, then freeze.
  task automatic one_step;
    run_en = 1'b1;
    repeat (328) @(negedge clk);
    run_en = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 hund",  3'd0, 8'h00);
    rd_chk("R1 sec",   3'd1, 8'h00);
    rd_chk("R1 min",   3'd2, 8'h00);
    rd_chk("R1 hour",  3'd3, 8'h00);
    rd_chk("R1 day",   3'd4, 8'h01);
    rd_chk("R1 date",  3'd5, 8'h01);
    rd_chk("R1 month", 3'd6, 8'h01);
    rd_chk("R1 year",  3'd7, 8'h00);
  endtask

  task automatic t_readback;
    run_en = 1'b0;
    set_all(8'h37, 8'h45, 8'h12, 8'h65, 8'h04, 8'h28, 8'h11, 8'h42);
    rd_chk("R2 hund",  3'd0, 8'h37);
    rd_chk("R2 sec",   3'd1, 8'h45);
    rd_chk("R2 min",   3'd2, 8'h12);
    rd_chk("R2 hour",  3'd3, 8'h65);
    rd_chk("R2 day",   3'd4, 8'h04);
    rd_chk("R2 date",  3'd5, 8'h28);
    rd_chk("R2 month", 3'd6, 8'h11);
    rd_chk("R2 year",  3'd7, 8'h42);
    wr(3'd4, 8'hFD); rd_chk("R2 day mask",  3'd4, 8'h05);
    wr(3'd5, 8'hE5); rd_chk("R2 date mask", 3'd5, 8'h25);
  endtask

  task automatic t_prescaler;
    run_en = 1'b0;
    rd_sel = 3'd1;
    wr(3'd1, 8'h00);
    run_en = 1'b1;
    wr(3'd0, 8'h00);
    repeat (32768) @(negedge clk);
    chk("R3 sec before 32768", rd_data, 8'h00);
    @(negedge clk);
    chk("R3 sec at 32768", rd_data, 8'h01);
    run_en = 1'b0;
  endtask

  task automatic t_wr_clear;
    rd_sel = 3'd0;
    run_en = 1'b1;
    wr(3'd0, 8'h00);
    repeat (200) @(negedge clk);
    wr(3'd2, 8'h10);
    repeat (328) @(negedge clk);
    chk("R12 hund before step", rd_data, 8'h00);
    @(negedge clk);
    chk("R12 hund after step", rd_data, 8'h01);
    run_en = 1'b0;
  endtask

  task automatic t_hold;
    run_en = 1'b0;
    set_all(8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    repeat (1000) @(negedge clk);
    rd_chk("R4 hund held", 3'd0, 8'h99);
    rd_chk("R4 year held", 3'd7, 8'h99);
  endtask

  task automatic t_carry;
    set_all(8'h99, 8'h59, 8'h59, 8'h10, 8'h02, 8'h05, 8'h03, 8'h23);
    one_step;
    rd_chk("R5 hund", 3'd0, 8'h00);
    rd_chk("R5 sec",  3'd1, 8'h00);
    rd_chk("R5 min",  3'd2, 8'h00);
    rd_chk("R5 hour", 3'd3, 8'h11);
    rd_chk("R8 day unchanged", 3'd4, 8'h02);
  endtask

  task automatic t_year_end;
    set_all(8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    one_step;
    rd_chk("R6 hour wrap", 3'd3, 8'h00);
    rd_chk("R8 day wrap",  3'd4, 8'h01);
    rd_chk("R11 date",     3'd5, 8'h01);
    rd_chk("R11 month",    3'd6, 8'h01);
    rd_chk("R11 year",     3'd7, 8'h00);
  endtask

  task automatic t_12h;
    set_all(8'h99, 8'h59, 8'h59, 8'h51, 8'h03, 8'h15, 8'h06, 8'h23);
    one_step;
    rd_chk("R7 11AM->12PM", 3'd3, 8'h72);
    rd_chk("R7 date same",  3'd5, 8'h15);
    set_all(8'h99, 8'h59, 8'h59, 8'h72, 8'h03, 8'h15, 8'h06, 8'h23);
    one_step;
    rd_chk("R7 12PM->1PM", 3'd3, 8'h61);
    set_all(8'h99, 8'h59, 8'h59, 8'h71, 8'h03, 8'h15, 8'h06, 8'h23);
    one_step;
    rd_chk("R7 11PM->12AM", 3'd3, 8'h52);
    rd_chk("R7 date adv",   3'd5, 8'h16);
    rd_chk("R8 day adv",    3'd4, 8'h04);
  endtask

  task automatic month_case(input string tag, input logic [7:0] dt, mo, yr,
                            input logic [7:0] exp_dt, exp_mo);
    set_all(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, dt, mo, yr);
    one_step;
    rd_chk({tag, " date"},  3'd5, exp_dt);
    rd_chk({tag, " month"}, 3'd6, exp_mo);
  endtask

  task automatic t_months;
    month_case("R9 jan31",      8'h31, 8'h01, 8'h23, 8'h01, 8'h02);
    month_case("R9 apr30",      8'h30, 8'h04, 8'h23, 8'h01, 8'h05);
    month_case("R9 jul30",      8'h30, 8'h07, 8'h23, 8'h31, 8'h07);
    month_case("R9 feb28 y23",  8'h28, 8'h02, 8'h23, 8'h01, 8'h03);
    month_case("R10 feb28 y24", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02);
    month_case("R10 feb29 y24", 8'h29, 8'h02, 8'h24, 8'h01, 8'h03);
    month_case("R10 feb28 y00", 8'h28, 8'h02, 8'h00, 8'h29, 8'h02);
    month_case("R10 feb28 y98", 8'h28, 8'h02, 8'h98, 8'h01, 8'h03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_readback;
    t_prescaler;
    t_wr_clear;
    t_hold;
    t_carry;
    t_year_end;
    t_12h;
    t_months;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=%h exp=%h", 8'h00, 8'h01);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule